// File: doc/BRIEF.md
# Memory Access Event Matcher

This block watches the stream of memory-access events that a 16-bit processor core emits while it executes, and tells which of its programmed watch entries an event concerns. Each event arrives as a one-cycle strobe carrying a three-bit flag vector and the effective memory address of the operand access. The core reports an event only for operands that really touch memory, never for register or literal operands. Within one instruction it reports the source operand's read first, then the destination operand's read, then the destination operand's write. The matcher does not reorder or merge anything: each strobe gets its own verdict.

Every watch entry holds a valid bit, a required-flags mask and an alternative-flags mask. An entry fires on an event when all bits of its required mask are present in the event flags and at least one bit of its alternative mask is present too. All entries are evaluated in parallel on the strobe. One cycle later the block presents a per-entry hit vector together with the captured address. Entries are loaded through a single write port, one entry per cycle.

Top module: `mem_event_matcher`

## Requirements
- R1: After a synchronous active-low reset, `hit` is all zeros, `hit_addr` is zero and every entry is invalid, so an event with all flags set produces no hit.
- R2: An entry fires only if the bitwise AND of its required mask with the event flags equals the required mask. Flag encoding is bit 0 = memory access, bit 1 = read, bit 2 = write.
- R3: An entry fires only if the AND of its alternative mask with the event flags is nonzero. An entry with a zero alternative mask never fires, and an event with zero flags fires no entry.
- R4: An entry whose valid bit is 0 never fires. Writing an entry with `cfg_valid` = 0 disables it.
- R5: The hit vector for an event appears exactly one cycle after the `ev_valid` strobe, with `hit_addr` equal to that event's `ev_addr`. In a cycle after one without a strobe, `hit` is all zeros.
- R6: `hit_addr` keeps its value in every cycle that follows a cycle without a strobe.
- R7: An entry write issued in the same cycle as an event does not affect that event's verdict. It applies from the next event onward.
- R8: Events on consecutive cycles produce hit vectors on consecutive cycles, in the same order, each with its own address.
- R9: Entries are independent: several entries can fire on the same event, each on its own masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one watch entry |
| cfg_idx | input | 3 | Index of the entry being written |
| cfg_all_mask | input | 3 | Required-flags mask to store |
| cfg_any_mask | input | 3 | Alternative-flags mask to store |
| cfg_valid | input | 1 | Valid bit to store |
| ev_valid | input | 1 | Event strobe, one cycle per event |
| ev_flags | input | 3 | Event flags: bit 0 memory, bit 1 read, bit 2 write |
| ev_addr | input | 16 | Effective memory address of the access |
| hit | output | 8 | Per-entry hit, registered one cycle after the strobe |
| hit_addr | output | 16 | Address captured with the last event |

## Verification
The table is filled with entries that differ in one mask at a time: a read-only watch, a write-only watch, a zero alternative mask, a disabled entry, an all-flags requirement and two permissive entries. Events of each flag kind are then played against it. Read and write events tell the required-mask test apart from the alternative-mask test. The zero-flag event and the zero-mask entry show the nonzero rule on both sides. The all-flags event exercises simultaneous hits. Back-to-back strobes, idle gaps, a reprogram that lands in the same cycle as an event, and the disabling of a firing entry separate the timing and ordering rules from the matching rule itself.

// File: rtl/mae_pkg.sv
// Shared definitions for the memory access event matcher.
// Assumes a three-bit event flag vector whose bit positions are fixed
// by the event source: memory access, read, write.
package mae_pkg;
    localparam int FLAG_W   = 3;
    localparam int FLAG_MEM = 0;
    localparam int FLAG_RD  = 1;
    localparam int FLAG_WR  = 2;

    // One programmable watch entry.
    typedef struct packed {
        logic              valid;
        logic [FLAG_W-1:0] all_m;
        logic [FLAG_W-1:0] any_m;
    } watch_entry_t;
endpackage

// File: rtl/mae_entry_table.sv
// Register bank holding the watch entries.
// One entry may be written per cycle through wr_en/wr_idx. The new value
// is visible from the next cycle. Reset clears every entry, valid bits
// included. Assumes wr_idx is below NUM_ENTRIES when wr_en is high.
module mae_entry_table
    import mae_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  watch_entry_t                   wr_entry,
    output watch_entry_t [NUM_ENTRIES-1:0] tbl
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        // Store the entry addressed by the write port; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                tbl[g] <= wr_entry;
            end
        end
    end
endmodule

// File: rtl/mae_match_unit.sv
// Combinational evaluation of every watch entry against one event.
// An entry matches when it is valid, all of its required flags are
// present, and at least one of its alternative flags is present.
// Assumes the caller qualifies the result with the event strobe.
module mae_match_unit
    import mae_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic [FLAG_W-1:0]              flags,
    input  watch_entry_t [NUM_ENTRIES-1:0] tbl,
    output logic [NUM_ENTRIES-1:0]         match
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic [FLAG_W-1:0] req_seen;
        logic [FLAG_W-1:0] alt_seen;
        // Mask the event flags with each of the entry's masks.
        always_comb begin
            req_seen = tbl[g].all_m & flags;
            alt_seen = tbl[g].any_m & flags;
        end
        // Combine validity, required-set and alternative-set tests.
        always_comb begin
            match[g] = tbl[g].valid
                     && (req_seen == tbl[g].all_m)
                     && (alt_seen != '0);
        end
    end
endmodule

// File: rtl/mem_event_matcher.sv
// Memory access event matcher top level.
// Holds the watch table, evaluates all entries in the cycle of the event
// strobe, and registers the hit vector and the event address for one
// cycle later. A table write in the same cycle as an event lands at the
// same clock edge, so it cannot change that event's verdict.
module mem_event_matcher
    import mae_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [FLAG_W-1:0]      cfg_all_mask,
    input  logic [FLAG_W-1:0]      cfg_any_mask,
    input  logic                   cfg_valid,
    input  logic                   ev_valid,
    input  logic [FLAG_W-1:0]      ev_flags,
    input  logic [ADDR_W-1:0]      ev_addr,
    output logic [NUM_ENTRIES-1:0] hit,
    output logic [ADDR_W-1:0]      hit_addr
);
    watch_entry_t [NUM_ENTRIES-1:0] tbl;
    watch_entry_t                   wr_entry;
    logic [NUM_ENTRIES-1:0]         match;

    // Pack the write-port fields into one entry value.
    always_comb begin
        wr_entry.valid = cfg_valid;
        wr_entry.all_m = cfg_all_mask;
        wr_entry.any_m = cfg_any_mask;
    end

    mae_entry_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_entry (wr_entry),
        .tbl      (tbl)
    );

    mae_match_unit #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .flags (ev_flags),
        .tbl   (tbl),
        .match (match)
    );

    // Register the strobe-qualified verdict one cycle after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= '0;
        end else begin
            hit <= ev_valid ? match : '0;
        end
    end

    // Capture the event address on every strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_addr <= '0;
        end else if (ev_valid) begin
            hit_addr <= ev_addr;
        end
    end

    // R5
    hit_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> $past(ev_valid));

    // R5
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_valid) |-> (hit_addr == $past(ev_addr)));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ev_valid) |-> $stable(hit_addr));

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
        // R4
        hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> $past(tbl[g].valid));

        // R2
        hit_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> (($past(tbl[g].all_m) & $past(ev_flags)) == $past(tbl[g].all_m)));

        // R3
        hit_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> (($past(tbl[g].any_m) & $past(ev_flags)) != '0));
    end
endmodule

// File: tb/sim_mem_event_matcher.sv
module sim_mem_event_matcher;
    localparam int N  = 8;
    localparam int AW = 16;
    localparam int FW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [FW-1:0] cfg_all_mask = '0;
    logic [FW-1:0] cfg_any_mask = '0;
    logic          cfg_valid = 1'b0;
    logic          ev_valid = 1'b0;
    logic [FW-1:0] ev_flags = '0;
    logic [AW-1:0] ev_addr = '0;
    logic [N-1:0]  hit;
    logic [AW-1:0] hit_addr;

    mem_event_matcher #(.NUM_ENTRIES(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_all_mask(cfg_all_mask), .cfg_any_mask(cfg_any_mask),
        .cfg_valid(cfg_valid), .ev_valid(ev_valid), .ev_flags(ev_flags),
        .ev_addr(ev_addr), .hit(hit), .hit_addr(hit_addr)
    );

    always #4 clk = ~clk;

    // Reference model: a plain table of integers and an expectation pipe.
    int          m_all [N];
    int          m_any [N];
    bit          m_val [N];
    logic [N-1:0]  exp_hit = '0;
    logic [AW-1:0] exp_addr = '0;
    string       cur_tag = "R1";
    string       exp_tag = "R1";
    int          checks = 0;
    int          fails = 0;
    bit          cmp_on = 1'b0;
    bit          done = 1'b0;
    int          cyc = 0;

    always @(posedge clk) begin : model
        logic [N-1:0] h;
        h = '0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_all[i] = 0; m_any[i] = 0; m_val[i] = 1'b0;
            end
            exp_hit  <= '0;
            exp_addr <= '0;
        end else begin
            if (ev_valid) begin
                for (int i = 0; i < N; i++) begin
                    int need_ok;
                    int alt_cnt;
                    need_ok = 1;
                    alt_cnt = 0;
                    for (int b = 0; b < FW; b++) begin
                        if (m_all[i][b] && !ev_flags[b]) need_ok = 0;
                        if (m_any[i][b] && ev_flags[b])  alt_cnt++;
                    end
                    if (m_val[i] && need_ok == 1 && alt_cnt > 0) h[i] = 1'b1;
                end
                exp_addr <= ev_addr;
            end
            exp_hit <= h;
            if (cfg_we) begin
                m_all[cfg_idx] = int'(cfg_all_mask);
                m_any[cfg_idx] = int'(cfg_any_mask);
                m_val[cfg_idx] = cfg_valid;
            end
        end
        exp_tag <= cur_tag;
    end

    // Compare outputs against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            checks++;
            if (hit !== exp_hit || hit_addr !== exp_addr) begin
                fails++;
                $display("FAIL %s: hit=%b hit_addr=%h expected hit=%b hit_addr=%h",
                         exp_tag, hit, hit_addr, exp_hit, exp_addr);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion before 5000", cyc);
            finish_run();
        end
    end

    task automatic step(input string tag, input bit ev, input int fl, input int ad,
                        input bit we, input int idx, input int am, input int om, input bit v);
        @(negedge clk);
        cur_tag      = tag;
        ev_valid     = ev;
        ev_flags     = FW'(fl);
        ev_addr      = AW'(ad);
        cfg_we       = we;
        cfg_idx      = IW'(idx);
        cfg_all_mask = FW'(am);
        cfg_any_mask = FW'(om);
        cfg_valid    = v;
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic event_(input string tag, input int fl, input int ad);
        step(tag, 1, fl, ad, 0, 0, 0, 0, 0);
    endtask

    task automatic prog(input string tag, input int idx, input int am, input int om, input bit v);
        step(tag, 0, 0, 0, 1, idx, am, om, v);
    endtask

    initial begin
        // R1: reset state and empty table
        idle("R1");
        idle("R1");
        cmp_on = 1'b1;
        idle("R1");
        rst_n = 1'b1;
        event_("R1", 7, 'h1111);
        idle("R1");
        idle("R1");

        // Table: 0 read watch, 1 write watch, 2 write-only required,
        // 3 zero alternative mask, 4 disabled, 5 all flags, 6/7 permissive
        prog("R2", 0, 3, 1, 1);
        prog("R2", 1, 0, 4, 1);
        prog("R2", 2, 5, 7, 1);
        prog("R3", 3, 0, 0, 1);
        prog("R4", 4, 1, 6, 0);
        prog("R9", 5, 7, 1, 1);
        prog("R9", 6, 1, 1, 1);
        prog("R9", 7, 1, 1, 1);
        idle("R2");

        // R2: read and write events
        event_("R2", 3, 'h2000);
        idle("R2");
        event_("R2", 5, 'h2004);
        idle("R2");
        // R3: memory-only and zero-flag events
        event_("R3", 1, 'h3000);
        idle("R3");
        event_("R3", 0, 'h3002);
        idle("R3");
        // R9: all flags fire several entries at once
        event_("R9", 7, 'hFFFF);
        idle("R9");

        // R8: one instruction's read, read, write sequence back to back
        event_("R8", 3, 'h4010);
        event_("R8", 3, 'h4020);
        event_("R8", 5, 'h4020);
        // R6: hold the last address through idle cycles
        idle("R6");
        idle("R6");
        idle("R6");

        // R7: disable entry 6 in the same cycle as an event
        step("R7", 1, 1, 'h5000, 1, 6, 1, 1, 0);
        event_("R7", 1, 'h5001);
        idle("R7");

        // R4: disable entry 0, then re-enable entry 4
        prog("R4", 0, 3, 1, 0);
        event_("R4", 3, 'h6000);
        prog("R4", 4, 1, 6, 1);
        event_("R4", 3, 'h6002);
        idle("R4");

        // R5: isolated strobe after a gap
        idle("R5");
        event_("R5", 5, 'h7ABC);
        idle("R5");
        idle("R5");

        finish_run();
    end
endmodule